// File: doc/BRIEF.md
# OFDMA Symbol Output Assembler

This block turns a store of already-mapped data subcarriers into a complete frequency-domain OFDMA symbol, one FFT-length burst for each request. It walks every bin from the most negative frequency up to the most positive. Each bin is classed as null, pilot or data. Null bins are the two guard bands and the DC bin. The pilot positions repeat with a fixed stride across the used band. Data bins take the next word from an internal symbol memory, which is read at addresses 0, 1, 2 and so on.

An 11-bit pseudo-random sequence, seeded from one of two cell identities and the symbol offset, supplies one sign bit per bin. Pilots are sent as a runtime boost amplitude, or as that amplitude negated. Data samples keep their value or are negated on both components by the same sign bit. All negations saturate. The symbol leaves on a streaming port with valid/ready handshake, ready latency one. An antenna tag travels with the symbol.

An upstream writer fills the memory through a simple write port. It then raises `sym_req` with the per-symbol settings. While a symbol is being emitted, further requests are dropped.

Top module: `ofdma_sym_assembler`

## Requirements
- R1: An accepted request yields exactly N valid samples, for bins -N/2 up to +N/2-1 in rising order. `out_first` is 1 on the first of them only.
- R2: With bin index k = 0..N-1, bins k < GUARD_LO, k >= N-GUARD_HI and k = N/2 (DC) output the word 0.
- R3: Number the used non-DC bins u = 0,1,2,... from the low edge. A bin with u mod PILOT_STRIDE = 0 is a pilot. Its real part is `pilot_boost` when the sign bit is 0 and the negated boost when it is 1. Its imaginary part is 0.
- R4: The remaining bins are data bins. They take memory words at addresses 0,1,2,... in bin order. Each 16-bit component is passed through when the sign bit is 0 and negated when it is 1.
- R5: The sign sequence is an 11-bit LFSR with feedback x^11+x^9+1. It shifts left and its new bit 0 is state[10] XOR state[8]. It is seeded with {cell id, sym_offset}, where the cell id is `cell_id_dflt` when `sym_cell_sel`=0 and `cell_id_alt` when it is 1. An all-zero seed is replaced by 11'h7FF. The sign bit of a bin is state[10] before the step, and the state steps once per bin.
- R6: The output word holds the real part in bits 15:0 and the imaginary part in bits 31:16. `out_valid` is 1 only in the cycle after a cycle with `out_ready`=1, and no bin is lost or repeated under backpressure.
- R7: `out_antenna` takes the request's `sym_antenna` together with the first sample and holds it for the whole symbol.
- R8: With the default parameters (N=1024, guards 92 and 91, stride 7) a symbol has 120 pilots and 720 data bins, so it reads addresses 0 to 719.
- R9: Negating -32768 gives +32767, both for the pilot boost and for data components.
- R10: A `sym_req` raised while `busy`=1 is ignored. The running symbol carries on unchanged, and no extra symbol follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Symbol memory write strobe |
| wr_addr | input | 10 | Symbol memory write address |
| wr_data | input | 32 | Mapped data word, imaginary in 31:16, real in 15:0 |
| sym_req | input | 1 | Start a symbol (taken when not busy) |
| sym_cell_sel | input | 1 | 0 selects default cell id, 1 the alternate |
| sym_offset | input | 5 | Symbol offset used in the seed |
| sym_antenna | input | 4 | Antenna tag for this symbol |
| cell_id_dflt | input | 6 | Default cell identity |
| cell_id_alt | input | 6 | Alternate cell identity |
| pilot_boost | input | 16 | Signed pilot amplitude for a +1 pilot |
| out_ready | input | 1 | Downstream ready (latency one) |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 32 | Output sample, imaginary 31:16, real 15:0 |
| out_first | output | 1 | First sample of a symbol |
| out_antenna | output | 4 | Antenna tag of the symbol being output |
| busy | output | 1 | A symbol is still being issued |

## Verification
The embedded assertions check, on every cycle, the ready-latency rule for `out_valid`, that the antenna tag holds inside a symbol, that the LFSR never reaches the all-zero lock state, that bin indices advance by one per issued sample, and that the last bin of a symbol is reached with exactly the expected number of data reads. Only the bench scenarios can show the value of each bin against an independent model. That covers guard/DC zeroing, pilot placement and sign, data sign flipping, seed selection and the all-zero seed substitution, saturation at -32768, and dropping a request made mid-symbol, under both full throughput and random backpressure.

// File: rtl/sc_asm_pkg.sv
`timescale 1ns/1ps
package sc_asm_pkg;

  typedef enum logic [1:0] {
    BIN_NULL  = 2'd0,
    BIN_PILOT = 2'd1,
    BIN_DATA  = 2'd2
  } bin_kind_e;

  // Two's complement negation clamped so -32768 maps to +32767.
  function automatic logic [15:0] neg_sat(input logic [15:0] x);
    if (x == 16'h8000) return 16'h7FFF;
    return 16'(~x + 16'd1);
  endfunction

  function automatic logic [15:0] apply_sign(input logic [15:0] x, input logic flip);
    return flip ? neg_sat(x) : x;
  endfunction

endpackage

// File: rtl/sc_sign_lfsr.sv
`timescale 1ns/1ps
module sc_sign_lfsr #(
  parameter int W     = 11,
  parameter int TAP_A = 10,
  parameter int TAP_B = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic         sign_bit
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ALL_ONES;
    end else if (load) begin
      state <= (seed == '0) ? ALL_ONES : seed;
    end else if (step) begin
      state <= {state[W-2:0], state[TAP_A] ^ state[TAP_B]};
    end
  end

  assign sign_bit = state[W-1];

  // R5: the sequence must never fall into the all-zero lock state
  p_lfsr_live_r5: assert property (@(posedge clk) disable iff (rst)
    state != '0);

endmodule

// File: rtl/sc_bin_sequencer.sv
`timescale 1ns/1ps
module sc_bin_sequencer
  import sc_asm_pkg::*;
#(
  parameter int N        = 1024,
  parameter int GUARD_LO = 92,
  parameter int GUARD_HI = 91,
  parameter int STRIDE   = 7,
  parameter int DCNT     = 720,
  parameter int AW       = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          adv,
  output logic          busy,
  output logic          issue,
  output bin_kind_e     kind,
  output logic          first,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr
);
  localparam int KW = $clog2(N);
  localparam int PW = (STRIDE > 1) ? $clog2(STRIDE) : 1;
  localparam logic [KW-1:0] K_LAST  = KW'(N - 1);
  localparam logic [KW-1:0] K_DC    = KW'(N / 2);
  localparam logic [KW-1:0] K_GLO   = KW'(GUARD_LO);
  localparam logic [KW-1:0] K_GHI   = KW'(N - GUARD_HI);
  localparam logic [PW-1:0] PH_LAST = PW'(STRIDE - 1);

  logic [KW-1:0] k;
  logic [PW-1:0] phase;
  logic [AW-1:0] daddr;
  logic          last;

  always_comb begin
    if (k < K_GLO || k >= K_GHI || k == K_DC) kind = BIN_NULL;
    else if (phase == '0)                     kind = BIN_PILOT;
    else                                      kind = BIN_DATA;
  end

  assign issue   = busy & adv;
  assign first   = (k == '0);
  assign last    = (k == K_LAST);
  assign rd_en   = issue && (kind == BIN_DATA);
  assign rd_addr = daddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      k     <= '0;
      phase <= '0;
      daddr <= '0;
    end else if (go && !busy) begin
      busy  <= 1'b1;
      k     <= '0;
      phase <= '0;
      daddr <= '0;
    end else if (issue) begin
      k <= k + 1'b1;
      if (last) busy <= 1'b0;
      if (kind != BIN_NULL) phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      if (kind == BIN_DATA) daddr <= daddr + 1'b1;
    end
  end

  // R1: consecutive issues inside a symbol step the bin index by one
  p_bin_step_r1: assert property (@(posedge clk) disable iff (rst)
    (issue && !last) |=> (k == $past(k) + 1'b1));

  // R8: the final bin is reached after exactly DCNT data reads
  p_data_total_r8: assert property (@(posedge clk) disable iff (rst)
    (issue && last) |->
      (int'(daddr) + ((kind == BIN_DATA) ? 1 : 0) == DCNT));

endmodule

// File: rtl/sc_sym_ram.sv
`timescale 1ns/1ps
module sc_sym_ram #(
  parameter int DEPTH = 720,
  parameter int DW    = 32,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/ofdma_sym_assembler.sv
`timescale 1ns/1ps
module ofdma_sym_assembler
  import sc_asm_pkg::*;
#(
  parameter int N        = 1024,
  parameter int GUARD_LO = 92,
  parameter int GUARD_HI = 91,
  parameter int STRIDE   = 7,
  parameter int CELL_W   = 6,
  parameter int OFF_W    = 5,
  parameter int ANT_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [9:0]           wr_addr,
  input  logic [31:0]          wr_data,
  input  logic                 sym_req,
  input  logic                 sym_cell_sel,
  input  logic [OFF_W-1:0]     sym_offset,
  input  logic [ANT_W-1:0]     sym_antenna,
  input  logic [CELL_W-1:0]    cell_id_dflt,
  input  logic [CELL_W-1:0]    cell_id_alt,
  input  logic [15:0]          pilot_boost,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [31:0]          out_data,
  output logic                 out_first,
  output logic [ANT_W-1:0]     out_antenna,
  output logic                 busy
);
  localparam int USED = N - GUARD_LO - GUARD_HI - 1;
  localparam int DCNT = USED - (USED + STRIDE - 1) / STRIDE;
  localparam int AW   = 10;
  localparam int SW   = CELL_W + OFF_W;

  logic            issue, seq_first, rd_en, sign_bit, start;
  bin_kind_e       kind, kind_q;
  logic [AW-1:0]   rd_addr;
  logic [31:0]     rd_q;
  logic [ANT_W-1:0] req_ant;
  logic            pol_q;
  logic [SW-1:0]   seed;

  assign start = sym_req && !busy;
  assign seed  = {sym_cell_sel ? cell_id_alt : cell_id_dflt, sym_offset};

  sc_bin_sequencer #(
    .N(N), .GUARD_LO(GUARD_LO), .GUARD_HI(GUARD_HI),
    .STRIDE(STRIDE), .DCNT(DCNT), .AW(AW)
  ) u_seq (
    .clk(clk), .rst(rst), .go(sym_req), .adv(out_ready),
    .busy(busy), .issue(issue), .kind(kind), .first(seq_first),
    .rd_en(rd_en), .rd_addr(rd_addr)
  );

  sc_sign_lfsr #(.W(SW), .TAP_A(SW - 1), .TAP_B(SW - 3)) u_lfsr (
    .clk(clk), .rst(rst), .load(start), .seed(seed),
    .step(issue), .sign_bit(sign_bit)
  );

  sc_sym_ram #(.DEPTH(DCNT), .DW(32), .AW(AW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_first   <= 1'b0;
      out_antenna <= '0;
      req_ant     <= '0;
      kind_q      <= BIN_NULL;
      pol_q       <= 1'b0;
    end else begin
      if (start) req_ant <= sym_antenna;
      out_valid <= issue;
      if (issue) begin
        kind_q    <= kind;
        pol_q     <= sign_bit;
        out_first <= seq_first;
        if (seq_first) out_antenna <= req_ant;
      end
    end
  end

  always_comb begin
    unique case (kind_q)
      BIN_PILOT: out_data = {16'h0000, apply_sign(pilot_boost, pol_q)};
      BIN_DATA:  out_data = {apply_sign(rd_q[31:16], pol_q),
                             apply_sign(rd_q[15:0], pol_q)};
      default:   out_data = 32'h0;
    endcase
  end

  // R6: a sample may only appear one cycle after the sink was ready
  p_ready_latency_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(out_ready));

  // R7: the antenna tag changes only together with a first sample
  p_antenna_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_first) |-> $stable(out_antenna));

  // R10: no sample is produced unless a symbol was in progress
  p_valid_from_busy_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(busy));

endmodule

// File: tb/test_ofdma_sym_assembler.sv
`timescale 1ns/1ps
module test_ofdma_sym_assembler;
  localparam int N = 1024, GLO = 92, GHI = 91, STRIDE = 7, DCNT = 720;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        sym_req = 1'b0;
  logic        sym_cell_sel = 1'b0;
  logic [4:0]  sym_offset = '0;
  logic [3:0]  sym_antenna = '0;
  logic [5:0]  cell_id_dflt = '0;
  logic [5:0]  cell_id_alt = '0;
  logic [15:0] pilot_boost = '0;
  logic        out_ready = 1'b0;
  logic        out_valid, out_first, busy;
  logic [31:0] out_data;
  logic [3:0]  out_antenna;

  always #2.5 clk = ~clk;

  ofdma_sym_assembler i_ofdma_sym_assembler (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sym_req(sym_req), .sym_cell_sel(sym_cell_sel), .sym_offset(sym_offset),
    .sym_antenna(sym_antenna), .cell_id_dflt(cell_id_dflt),
    .cell_id_alt(cell_id_alt), .pilot_boost(pilot_boost),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_first(out_first), .out_antenna(out_antenna), .busy(busy)
  );

  typedef struct {
    logic [31:0] d;
    logic        first;
    logic [3:0]  ant;
    int          kind;
  } exp_t;

  exp_t        expq[$];
  logic [31:0] mem_m [DCNT];
  int total = 0, bad = 0, cyc = 0;
  bit rand_ready = 0, done = 0, rdy_seen = 0;

  function automatic logic [15:0] nsat(input logic [15:0] x, input bit f);
    if (!f) return x;
    if (x == 16'h8000) return 16'h7FFF;
    return 16'(-int'($signed(x)));
  endfunction

  // 0 null, 1 pilot, 2 data (R2, R3, R4)
  function automatic int kind_of(input int k);
    int u;
    if (k < GLO || k >= N - GHI || k == N / 2) return 0;
    u = (k < N / 2) ? k - GLO : k - GLO - 1;
    return (u % STRIDE == 0) ? 1 : 2;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural model of one symbol (R5 seed and stepping)
  task automatic build(input logic [5:0] id, input logic [4:0] off,
                       input logic [3:0] ant, input logic [15:0] boost);
    int s, a, ndata;
    bit p;
    exp_t e;
    s = {id, off};
    if (s == 0) s = 11'h7FF;
    a = 0; ndata = 0;
    for (int k = 0; k < N; k++) begin
      p = s[10];
      e.kind = kind_of(k);
      e.first = (k == 0);
      e.ant = ant;
      case (e.kind)
        1: e.d = {16'h0, nsat(boost, p)};
        2: begin
          e.d = {nsat(mem_m[a][31:16], p), nsat(mem_m[a][15:0], p)};
          a++; ndata++;
        end
        default: e.d = 32'h0;
      endcase
      expq.push_back(e);
      s = ((s << 1) & 32'h7FF) | (((s >> 10) ^ (s >> 8)) & 1);
    end
    // R8: model-side count of data bins for the default geometry
    chk(ndata == DCNT, "R8 data bin count", 32'(ndata), 32'(DCNT));
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        chk(rdy_seen, "R6 valid without prior ready", 32'(out_valid), 32'(0));
        if (expq.size() == 0) begin
          chk(1'b0, "R10 unexpected sample", out_data, 32'h0);
        end else begin
          exp_t e;
          string tag;
          e = expq.pop_front();
          tag = (e.kind == 0) ? "R2 null bin" :
                (e.kind == 1) ? "R3/R9 pilot bin" : "R4/R9 data bin";
          chk(out_data == e.d, tag, out_data, e.d);
          chk(out_first == e.first, "R1 first flag", 32'(out_first), 32'(e.first));
          chk(out_antenna == e.ant, "R7 antenna", 32'(out_antenna), 32'(e.ant));
        end
      end
      out_ready = rand_ready ? (($urandom % 10) < 6) : 1'b1;
      rdy_seen  = out_ready;
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic request(input bit sel, input logic [4:0] off, input logic [3:0] ant);
    @(negedge clk);
    sym_cell_sel = sel; sym_offset = off; sym_antenna = ant;
    sym_req = 1'b1;
    @(negedge clk);
    sym_req = 1'b0;
  endtask

  task automatic wait_drain();
    do @(negedge clk); while (expq.size() != 0 || busy);
    repeat (4) @(negedge clk);
    // R1: all N samples of the symbol were observed, none left over
    chk(expq.size() == 0 && !out_valid, "R1 symbol length",
        32'(expq.size()), 32'(0));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !busy, "R6 reset state", {busy, out_valid}, 32'h0);

    for (int i = 0; i < DCNT; i++) begin
      logic [15:0] re, im;
      re = 16'(i * 37 - 3000);
      im = 16'(500 - i * 11);
      if (i == 5) re = 16'h8000;   // R9 saturation source
      if (i == 6) im = 16'h8000;
      mem_m[i] = {im, re};
      wr_en = 1'b1; wr_addr = 10'(i); wr_data = mem_m[i];
      @(negedge clk);
    end
    wr_en = 1'b0;

    // Symbol A: zero seed substitution (R5), full throughput
    cell_id_dflt = 6'd0; cell_id_alt = 6'd45; pilot_boost = 16'd5461;
    build(6'd0, 5'd0, 4'd3, 16'd5461);
    request(1'b0, 5'd0, 4'd3);
    wait_drain();

    // Symbol B: alternate cell id, backpressure, boost -32768 (R9),
    // and a stray request mid-symbol that must be dropped (R10)
    rand_ready = 1;
    pilot_boost = 16'h8000;
    build(6'd45, 5'd17, 4'd9, 16'h8000);
    request(1'b1, 5'd17, 4'd9);
    repeat (100) @(negedge clk);
    request(1'b0, 5'd2, 4'd14);
    wait_drain();

    // Symbol C: default cell id non-zero, different antenna
    cell_id_dflt = 6'd13; pilot_boost = 16'hFC18;
    build(6'd13, 5'd31, 4'd6, 16'hFC18);
    request(1'b0, 5'd31, 4'd6);
    wait_drain();

    done = 1;
    finish_run();
  end
endmodule